// File: doc/BRIEF.md
# Translation and Exception Control Register Bank

This block holds the memory-mapped control state that a processor's address translation and exception logic consult: the translation control word, the page table entry high, low and assist words, the table base, the faulting address, and the trap, exception and interrupt event codes. Software reaches it over a simple register bus with one request per cycle. Every request gets a response one cycle later, carrying read data or an error flag. Some writes have side effects. Setting the invalidate bit of the translation control word produces a one-cycle invalidate strobe toward the TLB. Changing the address-space ID held in the page table entry high word produces a one-cycle flush strobe.

The bank also contains a 16-bit refresh count that advances each time it is read, three read-only identification words, and two optional bus control words that exist only when the `opt_en` input is high. A bad access does not change any state and returns zero data with the error flag set. A bad access is one to an unmapped offset, at the wrong width, a write to a read-only word, or a touch of an optional word while `opt_en` is low.

Top module: `mmu_ctl_regs`

## Requirements
- R1: Every cycle with `bus_req` high produces `rsp_valid` high in the next cycle. `rsp_rdata` and `rsp_err` in that cycle belong to the request. A write response carries rdata 0.
- R2: A word write to offset 0x00 (translation control) with bit 2 set pulses `tlb_inval` high for exactly the response cycle. The stored word keeps every written bit except bit 2, which always reads 0.
- R3: A word write to offset 0x04 (page table entry high) whose bits 7:0 differ from the stored bits 7:0 pulses `xlat_flush` in the response cycle. An equal value in those bits gives no pulse. All 32 bits are stored.
- R4: Offset 0x0C (page table assist) keeps only bits 3:0 of a write. The upper bits read 0.
- R5: Offsets 0x18, 0x1C and 0x20 (trap, exception and interrupt codes) keep only bits 10:0 of a write.
- R6: Offset 0x24 is a 16-bit refresh count, accessed at half width only. A read returns the current value and then adds one to it, wrapping at 0xFFFF to 0. A write loads the value.
- R7: Offsets 0x30, 0x34 and 0x38 return the parameter constants `VER_CPU`, `VER_CACHE` and `VER_REV` on word reads. A write to them is rejected with an error and changes nothing.
- R8: Offset 0x28 (32-bit, word width) and offset 0x2C (16-bit, half width) are optional bus control words. They are read and written normally when `opt_en` is 1. When `opt_en` is 0, any access to them raises an error.
- R9: An access to an unmapped offset, to any offset with the wrong width, or to a non-zero address in bits 1:0 raises `rsp_err` with `rsp_rdata` 0. It changes no register and fires no strobe. Size codes are 0 = byte, 1 = half, 2 = word.
- R10: Offsets 0x08 (page table entry low), 0x10 (table base) and 0x14 (fault address) store all 32 written bits.
- R11: After reset every stored word and the refresh count are 0, and `rsp_valid`, `tlb_inval` and `xlat_flush` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opt_en | input | 1 | Enables the two optional bus control words |
| bus_req | input | 1 | Request valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_size | input | 2 | Access width: 0 byte, 1 half, 2 word |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data, 0 on writes and errors |
| rsp_err | output | 1 | Previous request was rejected |
| tlb_inval | output | 1 | One-cycle request to invalidate the whole TLB |
| xlat_flush | output | 1 | One-cycle request to flush cached translations |

## Verification
A read of the refresh count returns a value and advances the count in the same clock edge, so a read issued in the very next cycle already sees the advanced value. The bench provokes this with refresh reads issued back to back with no idle cycle between them. It judges the result by requiring consecutive responses to differ by exactly one, including across the wrap from 0xFFFF to 0. In the same way, a write carrying the invalidate bit yields its strobe in the same cycle as its response. The bench checks the strobe, the response and the cleared stored bit together in that one response cycle.

// File: rtl/mmu_ctl_pkg.sv
package mmu_ctl_pkg;

    localparam int DATA_W   = 32;
    localparam int ASID_W   = 8;
    localparam int ASSIST_W = 4;
    localparam int CODE_W   = 11;
    localparam int RFCNT_W  = 16;
    localparam int OPTB_W   = 16;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_XLAT, SEL_PTEH, SEL_PTEL, SEL_PTEA, SEL_TBASE,
        SEL_FADDR, SEL_TRAP, SEL_EXC, SEL_IRQ, SEL_RFCNT, SEL_OPTA,
        SEL_OPTB, SEL_VCPU, SEL_VCACHE, SEL_VREV
    } reg_sel_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    // Offset of each register in the bank (byte address).
    function automatic reg_sel_e sel_of_offset(input logic [7:0] off);
        case (off)
            8'h00:   return SEL_XLAT;
            8'h04:   return SEL_PTEH;
            8'h08:   return SEL_PTEL;
            8'h0C:   return SEL_PTEA;
            8'h10:   return SEL_TBASE;
            8'h14:   return SEL_FADDR;
            8'h18:   return SEL_TRAP;
            8'h1C:   return SEL_EXC;
            8'h20:   return SEL_IRQ;
            8'h24:   return SEL_RFCNT;
            8'h28:   return SEL_OPTA;
            8'h2C:   return SEL_OPTB;
            8'h30:   return SEL_VCPU;
            8'h34:   return SEL_VCACHE;
            8'h38:   return SEL_VREV;
            default: return SEL_NONE;
        endcase
    endfunction

    function automatic acc_size_e width_of(input reg_sel_e s);
        return (s == SEL_RFCNT || s == SEL_OPTB) ? SZ_HALF : SZ_WORD;
    endfunction

    function automatic logic is_read_only(input reg_sel_e s);
        return (s == SEL_VCPU || s == SEL_VCACHE || s == SEL_VREV);
    endfunction

    function automatic logic is_optional(input reg_sel_e s);
        return (s == SEL_OPTA || s == SEL_OPTB);
    endfunction

endpackage

// File: rtl/mmu_ctl_decode.sv
module mmu_ctl_decode
    import mmu_ctl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              req,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              opt_en,
    output reg_sel_e          sel,
    output logic              err
);
    localparam int LOW_W = (ADDR_W < 8) ? ADDR_W : 8;

    reg_sel_e raw;
    logic     bad;
    logic     high_zero;

    always_comb begin
        high_zero = 1'b1;
        for (int i = 8; i < ADDR_W; i++) begin
            if (addr[i]) high_zero = 1'b0;
        end
        raw = high_zero ? sel_of_offset(8'(addr[LOW_W-1:0])) : SEL_NONE;
        bad = 1'b0;
        if (raw == SEL_NONE)                   bad = 1'b1;
        else if (acc_size_e'(size) != width_of(raw)) bad = 1'b1;
        else if (wr && is_read_only(raw))      bad = 1'b1;
        else if (is_optional(raw) && !opt_en)  bad = 1'b1;
        err = req && bad;
        sel = (req && !bad) ? raw : SEL_NONE;
    end

endmodule

// File: rtl/mmu_ctl_regfile.sv
module mmu_ctl_regfile
    import mmu_ctl_pkg::*;
#(
    parameter int          INV_BIT   = 2,
    parameter logic [31:0] VER_CPU   = 32'h0405_0A00,
    parameter logic [31:0] VER_CACHE = 32'h0080_2000,
    parameter logic [31:0] VER_REV   = 32'h0000_0310
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_sel_e          sel,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata_q,
    output logic              inval_q,
    output logic              flush_q
);
    logic [DATA_W-1:0]   xlat_q, pteh_q, ptel_q, tbase_q, faddr_q, opta_q;
    logic [ASSIST_W-1:0] ptea_q;
    logic [CODE_W-1:0]   trap_q, exc_q, irq_q;
    logic [RFCNT_W-1:0]  rf_q;
    logic [OPTB_W-1:0]   optb_q;
    logic [DATA_W-1:0]   rd_n;

    logic do_wr, do_rd;
    assign do_wr = (sel != SEL_NONE) && wr;
    assign do_rd = (sel != SEL_NONE) && !wr;

    always_comb begin
        case (sel)
            SEL_XLAT:   rd_n = xlat_q;
            SEL_PTEH:   rd_n = pteh_q;
            SEL_PTEL:   rd_n = ptel_q;
            SEL_PTEA:   rd_n = DATA_W'(ptea_q);
            SEL_TBASE:  rd_n = tbase_q;
            SEL_FADDR:  rd_n = faddr_q;
            SEL_TRAP:   rd_n = DATA_W'(trap_q);
            SEL_EXC:    rd_n = DATA_W'(exc_q);
            SEL_IRQ:    rd_n = DATA_W'(irq_q);
            SEL_RFCNT:  rd_n = DATA_W'(rf_q);
            SEL_OPTA:   rd_n = opta_q;
            SEL_OPTB:   rd_n = DATA_W'(optb_q);
            SEL_VCPU:   rd_n = VER_CPU;
            SEL_VCACHE: rd_n = VER_CACHE;
            SEL_VREV:   rd_n = VER_REV;
            default:    rd_n = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            xlat_q  <= '0; pteh_q <= '0; ptel_q <= '0; tbase_q <= '0;
            faddr_q <= '0; opta_q <= '0; ptea_q <= '0; trap_q  <= '0;
            exc_q   <= '0; irq_q  <= '0; rf_q   <= '0; optb_q  <= '0;
            rdata_q <= '0; inval_q <= 1'b0; flush_q <= 1'b0;
        end else begin
            rdata_q <= do_rd ? rd_n : '0;
            inval_q <= do_wr && (sel == SEL_XLAT) && wdata[INV_BIT];
            flush_q <= do_wr && (sel == SEL_PTEH) &&
                       (wdata[ASID_W-1:0] != pteh_q[ASID_W-1:0]);
            if (do_rd && sel == SEL_RFCNT) rf_q <= rf_q + 1'b1;
            if (do_wr) begin
                case (sel)
                    SEL_XLAT: begin
                        xlat_q <= wdata;
                        xlat_q[INV_BIT] <= 1'b0;
                    end
                    SEL_PTEH:  pteh_q  <= wdata;
                    SEL_PTEL:  ptel_q  <= wdata;
                    SEL_PTEA:  ptea_q  <= wdata[ASSIST_W-1:0];
                    SEL_TBASE: tbase_q <= wdata;
                    SEL_FADDR: faddr_q <= wdata;
                    SEL_TRAP:  trap_q  <= wdata[CODE_W-1:0];
                    SEL_EXC:   exc_q   <= wdata[CODE_W-1:0];
                    SEL_IRQ:   irq_q   <= wdata[CODE_W-1:0];
                    SEL_RFCNT: rf_q    <= wdata[RFCNT_W-1:0];
                    SEL_OPTA:  opta_q  <= wdata;
                    SEL_OPTB:  optb_q  <= wdata[OPTB_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    // R2
    inval_clear_chk: assert property (@(posedge clk) disable iff (rst)
        inval_q |-> (xlat_q[INV_BIT] == 1'b0));

    // R3
    flush_asid_chk: assert property (@(posedge clk) disable iff (rst)
        flush_q |-> (pteh_q[ASID_W-1:0] != $past(pteh_q[ASID_W-1:0])));

    // R6
    rfcnt_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (do_rd && sel == SEL_RFCNT) |=> (rf_q == $past(rf_q) + 16'd1));

endmodule

// File: rtl/mmu_ctl_regs.sv
module mmu_ctl_regs
    import mmu_ctl_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          INV_BIT   = 2,
    parameter logic [31:0] VER_CPU   = 32'h0405_0A00,
    parameter logic [31:0] VER_CACHE = 32'h0080_2000,
    parameter logic [31:0] VER_REV   = 32'h0000_0310
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              opt_en,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err,
    output logic              tlb_inval,
    output logic              xlat_flush
);
    reg_sel_e sel;
    logic     dec_err;

    mmu_ctl_decode #(.ADDR_W(ADDR_W)) u_decode (
        .req    (bus_req),
        .wr     (bus_wr),
        .addr   (bus_addr),
        .size   (bus_size),
        .opt_en (opt_en),
        .sel    (sel),
        .err    (dec_err)
    );

    mmu_ctl_regfile #(
        .INV_BIT   (INV_BIT),
        .VER_CPU   (VER_CPU),
        .VER_CACHE (VER_CACHE),
        .VER_REV   (VER_REV)
    ) u_regfile (
        .clk     (clk),
        .rst     (rst),
        .sel     (sel),
        .wr      (bus_wr),
        .wdata   (bus_wdata),
        .rdata_q (rsp_rdata),
        .inval_q (tlb_inval),
        .flush_q (xlat_flush)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= bus_req;
            rsp_err   <= dec_err;
        end
    end

    // R1
    rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req |=> rsp_valid);

    // R9
    err_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_rdata == '0 && !tlb_inval && !xlat_flush));

    // R2
    strobe_ok_chk: assert property (@(posedge clk) disable iff (rst)
        (tlb_inval || xlat_flush) |-> (rsp_valid && !rsp_err));

endmodule

// File: tb/mmu_ctl_regs_bench.sv
module mmu_ctl_regs_bench;
    localparam int          CLK_P = 10;
    localparam logic [31:0] VC    = 32'h0405_0A00;
    localparam logic [31:0] VK    = 32'h0080_2000;
    localparam logic [31:0] VR    = 32'h0000_0310;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        opt_en = 1'b0;
    logic        bus_req = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [1:0]  bus_size = 2'd2;
    logic [31:0] bus_wdata = '0;
    logic        rsp_valid, rsp_err, tlb_inval, xlat_flush;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int fails  = 0;

    always #(CLK_P/2) clk = ~clk;

    mmu_ctl_regs #(.ADDR_W(8), .VER_CPU(VC), .VER_CACHE(VK), .VER_REV(VR)) u_mmu_ctl_regs (
        .clk(clk), .rst(rst), .opt_en(opt_en), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .tlb_inval(tlb_inval), .xlat_flush(xlat_flush)
    );

    typedef struct packed {
        logic [3:0]  tag;
        logic        wr;
        logic [7:0]  addr;
        logic [1:0]  size;
        logic [31:0] wdata;
        logic [31:0] rdata;
        logic        err;
        logic        inval;
        logic        flush;
    } vec_t;

    localparam int NV = 43;
    localparam vec_t VECS [NV] = '{
        '{4'd11, 1'b0, 8'h00, 2'd2, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0},          // R11 reset value
        '{4'd2,  1'b1, 8'h00, 2'd2, 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b1, 1'b0},  // R2 strobe
        '{4'd2,  1'b0, 8'h00, 2'd2, 32'h0, 32'hFFFF_FFFB, 1'b0, 1'b0, 1'b0},  // R2 bit cleared
        '{4'd2,  1'b1, 8'h00, 2'd2, 32'h0000_0010, 32'h0, 1'b0, 1'b0, 1'b0},  // R2 no strobe
        '{4'd2,  1'b0, 8'h00, 2'd2, 32'h0, 32'h0000_0010, 1'b0, 1'b0, 1'b0},
        '{4'd3,  1'b1, 8'h04, 2'd2, 32'h1234_5601, 32'h0, 1'b0, 1'b0, 1'b1},  // R3 ASID change
        '{4'd3,  1'b1, 8'h04, 2'd2, 32'hABCD_EF01, 32'h0, 1'b0, 1'b0, 1'b0},  // R3 same ASID
        '{4'd3,  1'b0, 8'h04, 2'd2, 32'h0, 32'hABCD_EF01, 1'b0, 1'b0, 1'b0},
        '{4'd3,  1'b1, 8'h04, 2'd2, 32'hABCD_EF02, 32'h0, 1'b0, 1'b0, 1'b1},
        '{4'd4,  1'b1, 8'h0C, 2'd2, 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b0, 1'b0},  // R4
        '{4'd4,  1'b0, 8'h0C, 2'd2, 32'h0, 32'h0000_000F, 1'b0, 1'b0, 1'b0},
        '{4'd5,  1'b1, 8'h18, 2'd2, 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b0, 1'b0},  // R5
        '{4'd5,  1'b0, 8'h18, 2'd2, 32'h0, 32'h0000_07FF, 1'b0, 1'b0, 1'b0},
        '{4'd5,  1'b1, 8'h1C, 2'd2, 32'h1234_5678, 32'h0, 1'b0, 1'b0, 1'b0},
        '{4'd5,  1'b0, 8'h1C, 2'd2, 32'h0, 32'h0000_0678, 1'b0, 1'b0, 1'b0},
        '{4'd5,  1'b1, 8'h20, 2'd2, 32'hFFFF_F800, 32'h0, 1'b0, 1'b0, 1'b0},
        '{4'd5,  1'b0, 8'h20, 2'd2, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0},
        '{4'd6,  1'b1, 8'h24, 2'd1, 32'h0000_00FE, 32'h0, 1'b0, 1'b0, 1'b0},  // R6 load
        '{4'd6,  1'b0, 8'h24, 2'd1, 32'h0, 32'h0000_00FE, 1'b0, 1'b0, 1'b0},  // R6 back-to-back reads
        '{4'd6,  1'b0, 8'h24, 2'd1, 32'h0, 32'h0000_00FF, 1'b0, 1'b0, 1'b0},
        '{4'd6,  1'b0, 8'h24, 2'd1, 32'h0, 32'h0000_0100, 1'b0, 1'b0, 1'b0},
        '{4'd9,  1'b0, 8'h24, 2'd2, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0},          // R9 wrong width
        '{4'd9,  1'b0, 8'h24, 2'd1, 32'h0, 32'h0000_0101, 1'b0, 1'b0, 1'b0},  // R9 no increment
        '{4'd6,  1'b1, 8'h24, 2'd1, 32'h0000_FFFF, 32'h0, 1'b0, 1'b0, 1'b0},
        '{4'd6,  1'b0, 8'h24, 2'd1, 32'h0, 32'h0000_FFFF, 1'b0, 1'b0, 1'b0},
        '{4'd6,  1'b0, 8'h24, 2'd1, 32'h0, 32'h0000_0000, 1'b0, 1'b0, 1'b0},  // R6 wrap
        '{4'd7,  1'b0, 8'h30, 2'd2, 32'h0, VC, 1'b0, 1'b0, 1'b0},             // R7
        '{4'd7,  1'b1, 8'h30, 2'd2, 32'h1111_1111, 32'h0, 1'b1, 1'b0, 1'b0},
        '{4'd7,  1'b0, 8'h30, 2'd2, 32'h0, VC, 1'b0, 1'b0, 1'b0},
        '{4'd7,  1'b0, 8'h34, 2'd2, 32'h0, VK, 1'b0, 1'b0, 1'b0},
        '{4'd7,  1'b0, 8'h38, 2'd2, 32'h0, VR, 1'b0, 1'b0, 1'b0},
        '{4'd8,  1'b0, 8'h28, 2'd2, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0},          // R8 disabled
        '{4'd8,  1'b1, 8'h2C, 2'd1, 32'h0000_1234, 32'h0, 1'b1, 1'b0, 1'b0},
        '{4'd9,  1'b0, 8'h3C, 2'd2, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0},          // R9 unmapped
        '{4'd9,  1'b1, 8'h08, 2'd1, 32'h0000_0055, 32'h0, 1'b1, 1'b0, 1'b0},
        '{4'd9,  1'b0, 8'h08, 2'd2, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0},
        '{4'd10, 1'b1, 8'h08, 2'd2, 32'hDEAD_BEEF, 32'h0, 1'b0, 1'b0, 1'b0},  // R10
        '{4'd10, 1'b0, 8'h08, 2'd2, 32'h0, 32'hDEAD_BEEF, 1'b0, 1'b0, 1'b0},
        '{4'd10, 1'b1, 8'h10, 2'd2, 32'h8000_0001, 32'h0, 1'b0, 1'b0, 1'b0},
        '{4'd10, 1'b0, 8'h10, 2'd2, 32'h0, 32'h8000_0001, 1'b0, 1'b0, 1'b0},
        '{4'd10, 1'b1, 8'h14, 2'd2, 32'h0000_0001, 32'h0, 1'b0, 1'b0, 1'b0},
        '{4'd10, 1'b0, 8'h14, 2'd2, 32'h0, 32'h0000_0001, 1'b0, 1'b0, 1'b0},
        '{4'd9,  1'b1, 8'h00, 2'd0, 32'h0000_0004, 32'h0, 1'b1, 1'b0, 1'b0}   // R9 byte: no strobe
    };

    // Drive at a falling edge; the response appears after the next rising
    // edge and is sampled at the following falling edge. Requests are issued
    // back to back with no idle cycle between calls.
    task automatic access(input int tag, input logic wr, input logic [7:0] a,
                          input logic [1:0] sz, input logic [31:0] wd,
                          input logic [31:0] exp_rd, input logic exp_err,
                          input logic exp_inv, input logic exp_fl);
        bus_req = 1'b1; bus_wr = wr; bus_addr = a; bus_size = sz; bus_wdata = wd;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b1 || rsp_rdata !== exp_rd || rsp_err !== exp_err ||
            tlb_inval !== exp_inv || xlat_flush !== exp_fl) begin
            fails++;
            $display("FAIL R%0d (R1 response) addr=%h: got v=%b d=%h e=%b i=%b f=%b, expected v=1 d=%h e=%b i=%b f=%b",
                     tag, a, rsp_valid, rsp_rdata, rsp_err, tlb_inval, xlat_flush,
                     exp_rd, exp_err, exp_inv, exp_fl);
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11: outputs idle after reset
        checks++;
        if (rsp_valid !== 1'b0 || tlb_inval !== 1'b0 || xlat_flush !== 1'b0) begin
            fails++;
            $display("FAIL R11 reset outputs: got v=%b i=%b f=%b, expected 0 0 0",
                     rsp_valid, tlb_inval, xlat_flush);
        end
        for (int i = 0; i < NV; i++) begin
            access(int'(VECS[i].tag), VECS[i].wr, VECS[i].addr, VECS[i].size,
                   VECS[i].wdata, VECS[i].rdata, VECS[i].err, VECS[i].inval,
                   VECS[i].flush);
        end
        bus_req = 1'b0;
        @(negedge clk);
        // R1: idle cycle gives no response
        checks++;
        if (rsp_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 idle response: got %b, expected 0", rsp_valid);
        end
        // R8: optional words with the feature enabled
        opt_en = 1'b1;
        access(8, 1'b1, 8'h28, 2'd2, 32'hCAFE_F00D, 32'h0, 1'b0, 1'b0, 1'b0);
        access(8, 1'b0, 8'h28, 2'd2, 32'h0, 32'hCAFE_F00D, 1'b0, 1'b0, 1'b0);
        access(8, 1'b1, 8'h2C, 2'd1, 32'hFFFF_1234, 32'h0, 1'b0, 1'b0, 1'b0);
        access(8, 1'b0, 8'h2C, 2'd1, 32'h0, 32'h0000_1234, 1'b0, 1'b0, 1'b0);
        access(9, 1'b0, 8'h2C, 2'd2, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0);
        // R9: misaligned offset
        access(9, 1'b0, 8'h05, 2'd2, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0);
        // R2 and R3 strobes in consecutive cycles
        access(2, 1'b1, 8'h00, 2'd2, 32'h0000_0004, 32'h0, 1'b0, 1'b1, 1'b0);
        access(3, 1'b1, 8'h04, 2'd2, 32'h0000_0077, 32'h0, 1'b0, 1'b0, 1'b1);
        access(2, 1'b0, 8'h00, 2'd2, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0);
        bus_req = 1'b0;
        @(negedge clk);
        // R2: strobe lasts a single cycle
        checks++;
        if (tlb_inval !== 1'b0 || xlat_flush !== 1'b0) begin
            fails++;
            $display("FAIL R2 strobe length: got i=%b f=%b, expected 0 0", tlb_inval, xlat_flush);
        end
        // R11: reset clears stored state
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        access(11, 1'b0, 8'h04, 2'd2, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0);
        access(11, 1'b0, 8'h24, 2'd1, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0);
        bus_req = 1'b0;
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule